// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block collects a parameterized number of peripheral interrupt lines for a single processor. Each line can be set to latch on a rising edge or to follow its level. Every interrupt moves through four states: idle, pending, active, and active with a new request waiting. Among the interrupts that are pending, enabled and of sufficient urgency, one combinational selector picks a winner. A registered request line tells the processor that such a winner exists.

Software uses a small word-addressed register port. It sets the two global enables, the priority mask, the per-line enable and trigger-type bits, and a 4-bit priority for each line. To accept the winner, software reads the acknowledge register. The read returns the winner's number and marks it active. If nothing can be delivered, the read returns the reserved number 1023 and changes no state. To finish an interrupt, software writes its number to the completion register.

A lower priority value is more urgent. On equal values the lowest interrupt number wins. A line is eligible only when its priority value is strictly below the mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request output is low and every register reads zero. Every interrupt is idle, and an acknowledge read returns 1023.
- R2: An edge-type line (trigger bit 1) becomes pending on a rising edge of its input. It stays pending after the input falls, until it is acknowledged.
- R3: A level-type line (trigger bit 0) is pending only while its input is high. If the input falls before the acknowledge read, that read returns 1023.
- R4: An acknowledge read returns its data on the cycle after the read. The data carries the winning number in bits [9:0] and zeros above. The winner has the smallest priority value, and on a tie the lowest number. The read moves the winner from pending to active.
- R5: A line is eligible only if its enable bit is set and its priority value is strictly below the mask. Clearing the enable bit of a pending line before the read makes the read return 1023.
- R6: The acknowledge read returns 1023 and changes no state in three cases: the forwarding enable (control bit 0) is clear, the processor-side enable (control bit 1) is clear, or no line is eligible.
- R7: A new assertion of an active line moves it to active-with-request. Such a line cannot be acknowledged again until its completion write, which returns it to pending.
- R8: A completion write of the number of an active line makes that line idle. A completion write naming a line that is not active is ignored.
- R9: The request output is registered. It goes high one cycle after some eligible line is pending while both enables are set. It is low one cycle after either enable clears.
- R10: A completion write to an active edge-type line can fall in the same cycle as a new rising edge on that line. The line then ends pending.
- R11: The register map is as follows. 0x00 holds the control bits. 0x01 holds the mask in bits [3:0]. 0x02 holds the enables, one bit per line. 0x03 holds the trigger types. 0x04 is the acknowledge register. 0x05 is the completion register, taking the number in bits [9:0]. 0x10+n holds the priority of line n. The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Peripheral interrupt inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq_req | output | 1 | Registered interrupt request to the processor |

## Verification
Two functions can act on one line in the same cycle. One is a completion write to an active edge-type line; the other is a new rising edge arriving on that same line. The bench provokes this by raising the input on the exact clock that carries the completion write. It judges the result by a later acknowledge read, which must return that line, because the edge must leave the line pending and not idle. A second overlap is a level input that falls between the request going high and the acknowledge read. The bench judges it by requiring the read value 1023.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_BOTH = 2'd3
  } irq_state_t;

  localparam int unsigned SPUR_ID = 1023;

  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_MASK  = 1;
  localparam int unsigned A_EN    = 2;
  localparam int unsigned A_TRIG  = 3;
  localparam int unsigned A_ACK   = 4;
  localparam int unsigned A_EOI   = 5;
  localparam int unsigned A_PRIO  = 16;
endpackage

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_in,
  input  logic       edge_mode,
  input  logic       ack_take,
  input  logic       eoi_take,
  output irq_state_t state_q
);
  logic       in_q;
  logic       rise;
  logic       held;
  logic       assert_ev;
  irq_state_t state_d;

  always_comb begin
    rise      = irq_in & ~in_q;
    held      = edge_mode | irq_in;
    assert_ev = edge_mode ? rise : irq_in;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (assert_ev) state_d = ST_PEND;
      ST_PEND: begin
        if (ack_take)   state_d = ST_ACT;
        else if (!held) state_d = ST_IDLE;
      end
      ST_ACT: begin
        if (eoi_take)       state_d = assert_ev ? ST_PEND : ST_IDLE;
        else if (assert_ev) state_d = ST_BOTH;
      end
      ST_BOTH: begin
        if (eoi_take)   state_d = held ? ST_PEND : ST_IDLE;
        else if (!held) state_d = ST_ACT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      state_q <= ST_IDLE;
    end else begin
      in_q    <= irq_in;
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]             pend,
  input  logic [NUM_IRQ-1:0]             irq_en,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              pmask,
  output logic                           found,
  output logic [IDX_W-1:0]               win_id
);
  logic [NUM_IRQ-1:0] cand;
  logic [PRIO_W-1:0]  best;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      cand[i] = pend[i] & irq_en[i] & (prio[i] < pmask);
    end
  end

  // Scan from the top so that the lowest index wins among equal values.
  always_comb begin
    found  = 1'b0;
    best   = '0;
    win_id = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i] && (!found || (prio[i] <= best))) begin
        found  = 1'b1;
        best   = prio[i];
        win_id = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  input  logic [DATA_W-1:0]              ack_word,
  output logic                           dist_en,
  output logic                           cpu_en,
  output logic [PRIO_W-1:0]              pmask,
  output logic [NUM_IRQ-1:0]             irq_en,
  output logic [NUM_IRQ-1:0]             edge_sel,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic                           ack_rd,
  output logic                           eoi_vld,
  output logic [ID_W-1:0]                eoi_id,
  output logic [DATA_W-1:0]              reg_rdata
);
  logic               ctrl_we, mask_we, en_we, trig_we;
  logic [NUM_IRQ-1:0] prio_we;
  logic [DATA_W-1:0]  rdata_d;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    ctrl_we = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    mask_we = reg_wr && (reg_addr == ADDR_W'(A_MASK));
    en_we   = reg_wr && (reg_addr == ADDR_W'(A_EN));
    trig_we = reg_wr && (reg_addr == ADDR_W'(A_TRIG));
    ack_rd  = reg_rd && (reg_addr == ADDR_W'(A_ACK));
    eoi_vld = reg_wr && (reg_addr == ADDR_W'(A_EOI));
    eoi_id  = reg_wdata[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en  <= 1'b0;
      cpu_en   <= 1'b0;
      pmask    <= '0;
      irq_en   <= '0;
      edge_sel <= '0;
    end else begin
      if (ctrl_we) begin
        dist_en <= reg_wdata[0];
        cpu_en  <= reg_wdata[1];
      end
      if (mask_we) pmask    <= reg_wdata[PRIO_W-1:0];
      if (en_we)   irq_en   <= reg_wdata[NUM_IRQ-1:0];
      if (trig_we) edge_sel <= reg_wdata[NUM_IRQ-1:0];
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    assign prio_we[g] = reg_wr && (reg_addr == ADDR_W'(A_PRIO + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio[g] <= '0;
      else if (prio_we[g]) prio[g] <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (reg_addr == ADDR_W'(A_CTRL))      rdata_d = DATA_W'({cpu_en, dist_en});
    else if (reg_addr == ADDR_W'(A_MASK)) rdata_d = DATA_W'(pmask);
    else if (reg_addr == ADDR_W'(A_EN))   rdata_d = DATA_W'(irq_en);
    else if (reg_addr == ADDR_W'(A_TRIG)) rdata_d = DATA_W'(edge_sel);
    else if (reg_addr == ADDR_W'(A_ACK))  rdata_d = ack_word;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (reg_addr == ADDR_W'(A_PRIO + i)) rdata_d = DATA_W'(prio[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 10,
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_req
);
  logic                           dist_en, cpu_en;
  logic [PRIO_W-1:0]              pmask;
  logic [NUM_IRQ-1:0]             irq_en, edge_sel;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic                           ack_rd, eoi_vld;
  logic [ID_W-1:0]                eoi_id;
  logic [DATA_W-1:0]              ack_word;
  logic [NUM_IRQ-1:0]             pend, ack_take, eoi_hit;
  logic [NUM_IRQ-1:0][1:0]        st_vec;
  logic                           found, fwd_ok, ack_hit, req_d;
  logic [IDX_W-1:0]               win_id;

  irqc_regs #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ack_word(ack_word),
    .dist_en(dist_en), .cpu_en(cpu_en), .pmask(pmask), .irq_en(irq_en),
    .edge_sel(edge_sel), .prio(prio), .ack_rd(ack_rd), .eoi_vld(eoi_vld),
    .eoi_id(eoi_id), .reg_rdata(reg_rdata)
  );

  irqc_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .pend(pend), .irq_en(irq_en), .prio(prio), .pmask(pmask),
    .found(found), .win_id(win_id)
  );

  always_comb begin
    fwd_ok   = dist_en & cpu_en;
    ack_hit  = ack_rd & fwd_ok & found;
    req_d    = fwd_ok & found;
    ack_word = (fwd_ok && found) ? DATA_W'(win_id) : DATA_W'(SPUR_ID);
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    irq_state_t st;
    assign ack_take[g] = ack_hit && (win_id == IDX_W'(g));
    assign eoi_hit[g]  = eoi_vld && (eoi_id == ID_W'(g));
    irqc_src u_src (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in[g]), .edge_mode(edge_sel[g]),
      .ack_take(ack_take[g]), .eoi_take(eoi_hit[g]), .state_q(st)
    );
    assign pend[g]   = (st == ST_PEND);
    assign st_vec[g] = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= req_d;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dist_en,
  input logic                    cpu_en,
  input logic                    ack_rd,
  input logic                    ack_hit,
  input logic                    irq_req,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [NUM_IRQ-1:0]      edge_sel,
  input logic [NUM_IRQ-1:0]      ack_take,
  input logic [NUM_IRQ-1:0]      eoi_hit,
  input logic [NUM_IRQ-1:0][1:0] st_vec
);
  p_spur_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !ack_hit |=> reg_rdata == DATA_W'(1023));

  p_ack_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> reg_rdata < DATA_W'(NUM_IRQ));

  p_one_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_take));

  p_req_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dist_en && cpu_en) |=> !irq_req);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel[g] && st_vec[g] == 2'd1 && !ack_take[g] |=> st_vec[g] == 2'd1);

    p_take_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take[g] |=> st_vec[g][1]);

    p_eoi_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !st_vec[g][1] && eoi_hit[g] |=> !st_vec[g][1]);
  end
endmodule

bind prio_irq_ctrl irqc_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
  .ack_rd(ack_rd), .ack_hit(ack_hit), .irq_req(irq_req),
  .reg_rdata(reg_rdata), .edge_sel(edge_sel), .ack_take(ack_take),
  .eoi_hit(eoi_hit), .st_vec(st_vec)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
  localparam int N = 8;
  localparam logic [31:0] SPUR = 32'd1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // Monitor: compares each read result with the queued expectation.
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %0d expected %0d", t, reg_rdata, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = 6'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int i);
    irq_in[i] = 1'b1;
    @(negedge clk);
    irq_in[i] = 1'b0;
  endtask

  task automatic chk_req(input logic e, input string t);
    n_chk++;
    if (irq_req !== e) begin
      n_fail++;
      $display("FAIL %s: irq_req actual %0b expected %0b", t, irq_req, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk_req(1'b0, "R1 req after reset");
    rd(0, 32'd0, "R1 ctrl reset");
    rd(2, 32'd0, "R1 enable reset");
    rd(4, SPUR, "R1 ack after reset");

    // configuration: lines 0-3 edge, 4-7 level
    wr(0, 3); wr(1, 15); wr(2, 8'hFF); wr(3, 8'h0F);
    wr(16, 5); wr(17, 5); wr(18, 3); wr(19, 7);
    wr(20, 3); wr(21, 9); wr(22, 2); wr(23, 14);
    rd(1, 32'd15, "R11 mask readback");
    rd(18, 32'd3, "R11 prio2 readback");
    rd(3, 32'h0F, "R11 trig readback");

    // R2 edge latching and R9 registered request
    pulse(1);
    chk_req(1'b0, "R9 req one cycle late");
    step(1);
    chk_req(1'b1, "R2 R9 req after edge");
    step(3);
    chk_req(1'b1, "R2 edge held after input fell");
    rd(4, 32'd1, "R2 ack edge line");
    step(1);
    chk_req(1'b0, "R9 req drops after ack");
    wr(5, 1);

    // R3 level input
    irq_in[5] = 1'b1;
    step(2);
    chk_req(1'b1, "R3 level req");
    irq_in[5] = 1'b0;
    step(2);
    chk_req(1'b0, "R3 level req gone");
    rd(4, SPUR, "R3 level dropped before ack");

    // R4 priority and tie order; R7 level stays asserted
    irq_in[4] = 1'b1;
    pulse(0); pulse(1); pulse(2);
    rd(4, 32'd2, "R4 tie lowest id first");
    rd(4, 32'd4, "R4 second of tie");
    rd(4, 32'd0, "R4 next priority");
    rd(4, 32'd1, "R4 last priority");
    rd(4, SPUR, "R4 none left pending");
    wr(5, 4);
    rd(4, 32'd4, "R7 level active-pending back to pending");
    irq_in[4] = 1'b0;
    step(1);
    wr(5, 4);
    rd(4, SPUR, "R8 eoi made level idle");
    wr(5, 0); wr(5, 1); wr(5, 2);

    // R6 gating
    wr(0, 1);
    pulse(3);
    step(1);
    chk_req(1'b0, "R6 R9 req with cpu side off");
    rd(4, SPUR, "R6 cpu side off");
    wr(0, 2);
    rd(4, SPUR, "R6 forwarding off");
    wr(0, 3);
    step(1);
    chk_req(1'b1, "R9 req after re-enable");
    rd(4, 32'd3, "R6 state unchanged by refused reads");
    wr(5, 3);

    // R5 mask and enable
    wr(1, 7);
    pulse(3);
    step(1);
    chk_req(1'b0, "R5 prio equal to mask not eligible");
    rd(4, SPUR, "R5 mask blocks");
    wr(1, 8);
    rd(4, 32'd3, "R5 mask raised");
    wr(5, 3);
    wr(1, 15);
    pulse(0);
    wr(2, 8'hFE);
    rd(4, SPUR, "R5 disabled after request");
    wr(2, 8'hFF);
    rd(4, 32'd0, "R5 re-enabled edge still pending");
    wr(5, 0);

    // R7 edge while active
    pulse(1);
    rd(4, 32'd1, "R7 first ack");
    pulse(1);
    rd(4, SPUR, "R7 active-pending not acked");
    wr(5, 1);
    rd(4, 32'd1, "R7 eoi returns to pending");
    wr(5, 1);
    rd(4, SPUR, "R8 eoi made idle");

    // R8 eoi to non-active ignored
    wr(5, 6);
    pulse(2);
    wr(5, 2);
    rd(4, 32'd2, "R8 eoi to pending ignored");
    wr(5, 2);

    // R10 completion and new edge in the same cycle
    pulse(1);
    rd(4, 32'd1, "R10 setup ack");
    irq_in[1] = 1'b1;
    reg_wr = 1'b1; reg_addr = 6'd5; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0; irq_in[1] = 1'b0;
    rd(4, 32'd1, "R10 edge with eoi leaves pending");
    wr(5, 1);
    rd(4, SPUR, "R10 idle after final eoi");

    step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule